// File: doc/BRIEF.md
# Carrier Phase Recovery Loop

This block tracks the phase of the carrier under a real passband sample stream and turns the stream into in-phase and quadrature baseband samples. Each accepted input sample is multiplied by a cosine and a sine from an internal oscillator. The two products are smoothed by running-sum low-pass filters, one on each arm. The difference between the two filtered arms is the phase error. This error goes through a first-order fixed-point loop filter and a gain stage. The result is added to the oscillator's phase step, so the local carrier follows the received one.

The nominal carrier is a quarter of the sample rate, which is a phase step of 0x4000 in a 16-bit accumulator. One cycle with `valid_i` high carries one sample through the whole loop. The outputs are registered and appear one cycle later with `valid_o`. The error output is there for lock monitoring. Symbol timing, matched filtering and bit decisions belong to later stages.

Top module: `carrier_phase_loop`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `valid_o`, `i_o`, `q_o` and `err_o` are zero. The phase, the loop-filter state and the filter histories are cleared.
- R2: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. In a cycle without `valid_i`, `i_o`, `q_o` and `err_o` keep their values.
- R3: Oscillator address a = phase[15:8]. The sine value is round(511*sin(2*pi*a/256)), with rounding symmetric about zero. The cosine value is the sine value at (a+64) mod 256.
- R4: For each accepted sample, phase becomes (phase + 0x4000 + corr) mod 2^16. The sample is mixed with the phase held before this update.
- R5: The in-phase product is x*cos and the quadrature product is x*sin. Both are exact, and x is signed 12-bit.
- R6: Each arm's output is the sum of that arm's last 16 products, including the current one, shifted arithmetically right by 4. Products before reset count as zero.
- R7: `err_o` = `q_o` - `i_o`, the negated difference of the filtered arms, on the same sample.
- R8: Loop-filter state L = clamp((13107*e + 19661*L_prev) >>> 15) to the range -32768..32767, where e is the error of the current sample.
- R9: corr = (4915*L) >>> 15, using the L just computed. It acts on the phase update of the same sample.
- R10: While the input is zero, the error stays zero and the phase advances by exactly 0x4000 per accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 12 | Signed passband sample |
| valid_i | input | 1 | Sample strobe |
| i_o | output | 22 | Signed filtered in-phase sample |
| q_o | output | 22 | Signed filtered quadrature sample |
| err_o | output | 23 | Signed phase-error estimate |
| valid_o | output | 1 | Output strobe |

## Verification
The hardest state to reach from the ports is a saturated loop filter. Its effect shows only later, as a changed oscillator phase once the error has drained away. The bench gets there with one full-scale negative impulse taken at phase zero. This drives a large error that stays in the 16-sample window for 16 samples. After a run of zero samples, a probe sample then shows where the clamped correction has left the oscillator. A second hard case is the nominal phase step, which cannot be seen while the input is zero. It is exposed by a single probe after five zero samples, which must land on the quarter-turn sine peak.

// File: rtl/cpl_pkg.sv
package cpl_pkg;
  localparam int COEF_Q   = 15;
  // 0.4, 0.6 and 0.15 in Q1.15, rounded
  localparam int COEF_X   = 13107;
  localparam int COEF_Y   = 19661;
  localparam int COEF_G   = 4915;
  localparam int NOM_STEP = 16384;
endpackage

// File: rtl/cpl_nco.sv
module cpl_nco #(
  parameter int PH_W   = 16,
  parameter int ADDR_W = 8,
  parameter int TAB_W  = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [PH_W-1:0]  corr_i,
  output logic        [PH_W-1:0]  phase_o,
  output logic signed [TAB_W-1:0] cos_o,
  output logic signed [TAB_W-1:0] sin_o
);
  localparam int QN  = 1 << (ADDR_W - 2);
  localparam int AMP = (1 << (TAB_W - 1)) - 1;
  localparam int TW  = (QN + 1) * TAB_W;
  localparam logic [PH_W-1:0] STEP = PH_W'(cpl_pkg::NOM_STEP);

  function automatic logic [TW-1:0] build_quarter();
    logic [TW-1:0] r;
    real           v;
    int            k;
    r = '0;
    for (int i = 0; i <= QN; i++) begin
      v = real'(AMP) * $sin(3.14159265358979323846 / 2.0 * real'(i) / real'(QN));
      k = $rtoi(v + 0.5);
      r[i*TAB_W +: TAB_W] = k[TAB_W-1:0];
    end
    return r;
  endfunction

  localparam logic [TW-1:0] QTAB = build_quarter();

  function automatic logic signed [TAB_W-1:0] lut(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-3:0]       idx;
    int                      k;
    logic signed [TAB_W-1:0] m;
    idx = a[ADDR_W-3:0];
    k   = a[ADDR_W-2] ? (QN - int'(idx)) : int'(idx);
    m   = $signed(QTAB[k*TAB_W +: TAB_W]);
    return a[ADDR_W-1] ? -m : m;
  endfunction

  logic [PH_W-1:0]   phase_q;
  logic [ADDR_W-1:0] addr;

  assign addr    = phase_q[PH_W-1 -: ADDR_W];
  assign sin_o   = lut(addr);
  assign cos_o   = lut(addr + ADDR_W'(QN));
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_q <= '0;
    else if (en_i) phase_q <= phase_q + STEP + corr_i;
  end
endmodule

// File: rtl/cpl_mavg.sv
module cpl_mavg #(
  parameter int D_W  = 22,
  parameter int TAPS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic signed [D_W-1:0] din_i,
  output logic signed [D_W-1:0] y_o
);
  localparam int LOG2  = $clog2(TAPS);
  localparam int SUM_W = D_W + LOG2;

  logic signed [D_W-1:0]   dl_q [TAPS];
  logic signed [SUM_W-1:0] sum_q, sum_nxt;

  assign sum_nxt = sum_q + SUM_W'(din_i) - SUM_W'(dl_q[TAPS-1]);
  assign y_o     = D_W'(sum_nxt >>> LOG2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      dl_q[0] <= '0;
    end else if (en_i) begin
      sum_q   <= sum_nxt;
      dl_q[0] <= din_i;
    end
  end

  for (genvar g = 1; g < TAPS; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   dl_q[g] <= '0;
      else if (en_i) dl_q[g] <= dl_q[g-1];
    end
  end
endmodule

// File: rtl/cpl_loop_filter.sv
module cpl_loop_filter #(
  parameter int ERR_W = 23,
  parameter int LF_W  = 16,
  parameter int PH_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic signed [PH_W-1:0]  corr_o
);
  localparam int ACC_W = 48;
  localparam logic signed [ACC_W-1:0] CX  = ACC_W'(cpl_pkg::COEF_X);
  localparam logic signed [ACC_W-1:0] CY  = ACC_W'(cpl_pkg::COEF_Y);
  localparam logic signed [ACC_W-1:0] CG  = ACC_W'(cpl_pkg::COEF_G);
  localparam logic signed [ACC_W-1:0] LIM_HI = (ACC_W'(1) <<< (LF_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] LIM_LO = -(ACC_W'(1) <<< (LF_W - 1));

  logic signed [LF_W-1:0]  lf_q, lf_nxt;
  logic signed [ACC_W-1:0] acc, acc_sh, gain;

  always_comb begin
    acc    = CX * ACC_W'(err_i) + CY * ACC_W'(lf_q);
    acc_sh = acc >>> cpl_pkg::COEF_Q;
    if (acc_sh > LIM_HI)      lf_nxt = LIM_HI[LF_W-1:0];
    else if (acc_sh < LIM_LO) lf_nxt = LIM_LO[LF_W-1:0];
    else                      lf_nxt = LF_W'(acc_sh);
    gain   = (CG * ACC_W'(lf_nxt)) >>> cpl_pkg::COEF_Q;
    corr_o = PH_W'(gain);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lf_q <= '0;
    else if (en_i) lf_q <= lf_nxt;
  end
endmodule

// File: rtl/carrier_phase_loop.sv
module carrier_phase_loop #(
  parameter int IN_W   = 12,
  parameter int TAB_W  = 10,
  parameter int PH_W   = 16,
  parameter int ADDR_W = 8,
  parameter int TAPS   = 16,
  parameter int LF_W   = 16,
  localparam int Y_W   = IN_W + TAB_W,
  localparam int ERR_W = Y_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  x_i,
  input  logic                    valid_i,
  output logic signed [Y_W-1:0]   i_o,
  output logic signed [Y_W-1:0]   q_o,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    valid_o
);
  logic [PH_W-1:0]          phase;
  logic signed [PH_W-1:0]   corr;
  logic signed [TAB_W-1:0]  lo [2];
  logic signed [Y_W-1:0]    mix [2];
  logic signed [Y_W-1:0]    y [2];
  logic signed [ERR_W-1:0]  err;

  cpl_nco #(.PH_W(PH_W), .ADDR_W(ADDR_W), .TAB_W(TAB_W)) u_nco (
    .clk_i, .rst_ni, .en_i(valid_i), .corr_i(corr),
    .phase_o(phase), .cos_o(lo[0]), .sin_o(lo[1])
  );

  // arm 0: in-phase (cosine), arm 1: quadrature (sine)
  for (genvar a = 0; a < 2; a++) begin : g_arm
    assign mix[a] = Y_W'(x_i) * Y_W'(lo[a]);
    cpl_mavg #(.D_W(Y_W), .TAPS(TAPS)) u_lpf (
      .clk_i, .rst_ni, .en_i(valid_i), .din_i(mix[a]), .y_o(y[a])
    );
  end

  assign err = ERR_W'(y[1]) - ERR_W'(y[0]);

  cpl_loop_filter #(.ERR_W(ERR_W), .LF_W(LF_W), .PH_W(PH_W)) u_lf (
    .clk_i, .rst_ni, .en_i(valid_i), .err_i(err), .corr_o(corr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_o     <= '0;
      q_o     <= '0;
      err_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        i_o   <= y[0];
        q_o   <= y[1];
        err_o <= err;
      end
    end
  end
endmodule

// File: rtl/cpl_checker.sv
module cpl_checker #(
  parameter int PH_W  = 16,
  parameter int Y_W   = 22,
  parameter int ERR_W = 23
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    valid_o,
  input logic signed [Y_W-1:0]   i_o,
  input logic signed [Y_W-1:0]   q_o,
  input logic signed [ERR_W-1:0] err_o,
  input logic [PH_W-1:0]         phase,
  input logic signed [PH_W-1:0]  corr
);
  localparam logic [PH_W-1:0] STEP = PH_W'(cpl_pkg::NOM_STEP);

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(i_o) && $stable(q_o) && $stable(err_o)));

  a_r4_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(phase));

  a_r10_nominal_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && corr == '0) |=> (phase == $past(phase) + STEP));
endmodule

bind carrier_phase_loop cpl_checker #(.PH_W(PH_W), .Y_W(Y_W), .ERR_W(ERR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .valid_o(valid_o),
  .i_o(i_o), .q_o(q_o), .err_o(err_o), .phase(phase), .corr(corr)
);

// File: tb/carrier_phase_loop_bench.sv
module carrier_phase_loop_bench;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic signed [11:0] x_i = '0;
  logic               valid_i = 1'b0;
  logic signed [21:0] i_o, q_o;
  logic signed [22:0] err_o;
  logic               valid_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #10ns clk_i = ~clk_i;

  carrier_phase_loop u_carrier_phase_loop (
    .clk_i, .rst_ni, .x_i, .valid_i, .i_o, .q_o, .err_o, .valid_o
  );

  // reference model state
  int     m_ph;
  longint m_lf, m_si, m_sq;
  longint m_dli [16];
  longint m_dlq [16];
  longint e_i, e_q, e_e;

  function automatic int tabv(input int a);
    real v;
    v = 511.0 * $sin(2.0 * 3.14159265358979323846 * real'(a) / 256.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic void model_clear();
    m_ph = 0; m_lf = 0; m_si = 0; m_sq = 0;
    e_i = 0; e_q = 0; e_e = 0;
    for (int k = 0; k < 16; k++) begin m_dli[k] = 0; m_dlq[k] = 0; end
  endfunction

  function automatic void model_step(input int x);
    int a; longint zi, zq, acc, l, cr;
    a  = m_ph >> 8;
    zi = longint'(x) * tabv((a + 64) % 256);
    zq = longint'(x) * tabv(a);
    m_si = m_si + zi - m_dli[15];
    m_sq = m_sq + zq - m_dlq[15];
    for (int k = 15; k > 0; k--) begin m_dli[k] = m_dli[k-1]; m_dlq[k] = m_dlq[k-1]; end
    m_dli[0] = zi; m_dlq[0] = zq;
    e_i = m_si >>> 4;
    e_q = m_sq >>> 4;
    e_e = e_q - e_i;
    acc = 13107 * e_e + 19661 * m_lf;
    l = acc >>> 15;
    if (l > 32767) l = 32767;
    if (l < -32768) l = -32768;
    m_lf = l;
    cr = (4915 * l) >>> 15;
    m_ph = int'((longint'(m_ph) + 16384 + cr) & 65535);
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    valid_i = 1'b0; x_i = '0; rst_ni = 1'b0;
    model_clear();
    repeat (3) @(negedge clk_i);
    check("R1 valid_o in reset", valid_o, 0);
    check("R1 i_o in reset", i_o, 0);
    check("R1 q_o in reset", q_o, 0);
    check("R1 err_o in reset", err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid_o after reset", valid_o, 0);
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic send(input int x, input string tag);
    x_i = 12'(x); valid_i = 1'b1;
    model_step(x);
    @(negedge clk_i);
    check({tag, " R2 valid_o"}, valid_o, 1);
    check({tag, " R6 i_o"}, i_o, e_i);
    check({tag, " R6 q_o"}, q_o, e_q);
    check({tag, " R7 err_o"}, err_o, e_e);
  endtask

  task automatic idle(input int n);
    valid_i = 1'b0; x_i = 12'sd777;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      check("R2 idle valid_o", valid_o, 0);
      check("R2 idle i_o hold", i_o, e_i);
      check("R2 idle q_o hold", q_o, e_q);
      check("R2 idle err_o hold", err_o, e_e);
    end
  endtask

  task automatic t_zero_then_probe();
    do_reset();
    for (int k = 0; k < 5; k++) begin
      send(0, "R10 zero");
      check("R10 err zero", err_o, 0);
    end
    send(100, "R4 probe");
    // phase 0x4000 -> sine peak 511, cosine 0: 100*511 >>> 4
    check("R4 probe q_o", q_o, 3193);
    check("R4 probe i_o", i_o, 0);
    check("R7 probe err_o", err_o, 3193);
    idle(2);
  endtask

  task automatic t_impulse();
    do_reset();
    send(100, "R5 impulse");
    check("R5 impulse i_o", i_o, 3193);
    check("R3 impulse q_o", q_o, 0);
    check("R7 impulse err_o", err_o, -3193);
    for (int k = 1; k < 16; k++) send(0, "R6 window");
    check("R6 last in window", i_o, 3193);
    send(0, "R6 leave");
    check("R6 after window", i_o, 0);
    idle(1);
  endtask

  task automatic t_saturate();
    do_reset();
    send(-2048, "R8 sat impulse");
    for (int k = 0; k < 30; k++) send(0, "R8 drain");
    for (int k = 0; k < 8; k++) send(600, "R9 probe");
    idle(2);
  endtask

  task automatic t_tone();
    real v;
    do_reset();
    for (int n = 0; n < 240; n++) begin
      v = 900.0 * $cos(1.5707963267948966 * real'(n) + 0.6 + 0.004 * real'(n));
      send((v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5), "R3 tone");
      if (n % 9 == 8) idle(2);
    end
    idle(1);
  endtask

  initial begin
    @(negedge clk_i);
    t_zero_then_probe();
    t_impulse();
    t_saturate();
    t_tone();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule